// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block keeps an asynchronous DRAM array with multiplexed row and column addresses alive. After reset it holds every strobe inactive for the power-up interval. It then runs a fixed number of dummy refresh cycles and raises `ready`. From then on it issues one refresh for every slot of the retention window. A slot is the retention time divided by the number of rows, so the rows are covered evenly. Each refresh is either CAS-before-RAS or RAS-only, selected by a plain mode pin. In the RAS-only form the sequencer supplies the row from a local counter.

The memory bus is shared with the normal access path. The block never drives it unless it has won it from the arbiter through a request/grant handshake. `bus_req` rises when a cycle is wanted. The cycle starts on the first clock that samples `bus_gnt` high while `bus_req` is high. The grant may be withheld for any number of cycles, which is the block's back-pressure. Once granted, `bus_req` stays high through the strobe phase and the RAS precharge, and falls in the cycle after the precharge ends.

While the grant is withheld, ticks that are due are counted as owed refreshes. Owed refreshes are served one after another once the grant returns. When the count of owed refreshes cannot grow any further, a sticky overflow flag is raised.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n` and `we_n` are 1, and `bus_req`, `row_addr_en`, `ready` and `overflow` are 0.
- R2: `bus_req` first rises exactly PWR_CYC = ceil(POWERUP_NS / CLK_PERIOD_NS) clocks after reset is released, and no strobe is active before that.
- R3: `ready` stays 0 until exactly INIT_CYCLES refresh cycles have completed, rises when the last one ends, and then stays 1 until reset.
- R4: Once `ready` is 1 and the grant is always given, exactly one refresh cycle starts per interval of floor(RETENTION_NS / 2^ROW_W / CLK_PERIOD_NS) clocks.
- R5: A strobe (`ras_n` or `cas_n` low, or `row_addr_en` high) is only active while `bus_req` is 1. No cycle starts while `bus_gnt` is held at 0; `bus_req` stays 1 while a refresh is waiting.
- R6: In a CAS-before-RAS cycle (`ras_only_mode` = 0 at the grant), `cas_n` falls at least one clock before `ras_n`, `row_addr_en` stays 0, and `we_n` is 1 at all times.
- R7: In a RAS-only cycle (`ras_only_mode` = 1 at the grant), `cas_n` stays 1. `row_addr_en` is 1 from at least one clock before `ras_n` falls until `ras_n` rises. `row_addr` holds steady during that time. `row_addr` equals a row counter that starts at 0 after reset, advances by 1 after each RAS-only cycle, and wraps from 2^ROW_W-1 to 0.
- R8: `ras_n` stays low for at least RAS_CYC clocks and high for at least PRE_CYC = ceil(PRECHARGE_NS / CLK_PERIOD_NS) clocks between cycles. Successive falls are at least ceil(CYCLE_NS / CLK_PERIOD_NS) clocks apart. RAS_CYC is the larger of ceil(RAS_LOW_NS / CLK_PERIOD_NS) and the full-cycle minimum minus PRE_CYC minus 1.
- R9: Up to MAX_DEBT owed refreshes are remembered and served back to back when the grant returns. A further tick while MAX_DEBT are owed is dropped and sets `overflow`, which stays 1 until reset.
- R10: The refresh form is taken from `ras_only_mode` on the clock that accepts the grant; changes at other times do not alter a cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_mode | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| bus_req | output | 1 | Request for, and ownership of, the memory bus |
| bus_gnt | input | 1 | Grant from the access arbiter |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row address for RAS-only cycles |
| row_addr_en | output | 1 | `row_addr` is to be driven onto the address bus |
| ready | output | 1 | Initialisation finished, array usable |
| overflow | output | 1 | Sticky: a refresh tick was lost |

## Verification
The bench runs a reduced configuration: a 50-clock power-up hold, 8 rows and a 400-clock refresh slot. With that configuration it steps through every phase in turn. Initialisation in RAS-only form walks all 8 row addresses, which separates correct row sequencing from a stuck or skipped counter. A ten-slot window in each refresh form checks the cadence and the strobe order and widths. The RAS-only window also passes the row wrap. A long grant stall first reaches exactly MAX_DEBT owed ticks with no overflow and then one more tick that sets the flag. That stall separates a saturating debt counter from a wrapping or unbounded one. It is followed by a count of the back-to-back cycles served once the grant returns.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_STROBE,
    ST_PRECH
  } rfsh_state_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned PERIOD_CYC = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned TW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == TW'(PERIOD_CYC - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + TW'(1);
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter #(
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic served,
  output logic owed,
  output logic overflow
);
  localparam int unsigned DW = $clog2(MAX_DEBT + 1);

  logic [DW-1:0] debt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      debt_q   <= '0;
      overflow <= 1'b0;
    end else begin
      unique case ({tick, served})
        2'b10: begin
          if (debt_q == DW'(MAX_DEBT)) overflow <= 1'b1;
          else                         debt_q   <= debt_q + DW'(1);
        end
        2'b01: begin
          if (debt_q != '0) debt_q <= debt_q - DW'(1);
        end
        default: ;
      endcase
    end
  end

  assign owed = (debt_q != '0);
endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
  import rfsh_pkg::*;
#(
  parameter int unsigned PWR_CYC     = 25000,
  parameter int unsigned RAS_CYC     = 8,
  parameter int unsigned PRE_CYC     = 5,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned ROW_W       = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             owed,
  input  logic             bus_gnt,
  input  logic             ras_only_mode,
  output logic             bus_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic             row_addr_en,
  output logic [ROW_W-1:0] row_addr,
  output logic             ready,
  output logic             served
);
  localparam int unsigned CMAX = umax(PWR_CYC, umax(RAS_CYC, PRE_CYC));
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned IW   = $clog2(INIT_CYCLES + 1);

  rfsh_state_e      st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             mode_q, mode_d;
  logic             done;
  logic             in_cyc_d;
  logic [IW-1:0]    init_q;
  logic             ready_q;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    done   = 1'b0;
    unique case (st_q)
      ST_HOLD: begin
        if (cnt_q == '0) st_d  = ST_REQ;
        else             cnt_d = cnt_q - CW'(1);
      end
      ST_IDLE: begin
        if (!ready_q || owed) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (bus_gnt) begin
          st_d   = ST_SETUP;
          mode_d = ras_only_mode;
        end
      end
      ST_SETUP: begin
        st_d  = ST_STROBE;
        cnt_d = CW'(RAS_CYC - 1);
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          st_d  = ST_PRECH;
          cnt_d = CW'(PRE_CYC - 1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_PRECH: begin
        if (cnt_q == '0) begin
          st_d = ST_IDLE;
          done = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: st_d = ST_HOLD;
    endcase
  end

  assign in_cyc_d = (st_d == ST_SETUP) || (st_d == ST_STROBE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_HOLD;
      cnt_q       <= CW'(PWR_CYC - 1);
      mode_q      <= 1'b0;
      init_q      <= '0;
      ready_q     <= 1'b0;
      row_q       <= '0;
      bus_req     <= 1'b0;
      ras_n       <= 1'b1;
      cas_n       <= 1'b1;
      row_addr_en <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      mode_q      <= mode_d;
      bus_req     <= (st_d == ST_REQ) || in_cyc_d || (st_d == ST_PRECH);
      ras_n       <= (st_d != ST_STROBE);
      cas_n       <= !(in_cyc_d && !mode_d);
      row_addr_en <= in_cyc_d && mode_d;
      if (done) begin
        if (mode_q) row_q <= row_q + ROW_W'(1);
        if (!ready_q) begin
          init_q <= init_q + IW'(1);
          if (init_q == IW'(INIT_CYCLES - 1)) ready_q <= 1'b1;
        end
      end
    end
  end

  assign ready    = ready_q;
  assign served   = done && ready_q;
  assign row_addr = row_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned POWERUP_NS    = 200000,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned ROW_W         = 11,
  parameter int unsigned RETENTION_NS  = 32000000,
  parameter int unsigned RAS_LOW_NS    = 60,
  parameter int unsigned PRECHARGE_NS  = 40,
  parameter int unsigned CYCLE_NS      = 110,
  parameter int unsigned MAX_DEBT      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_mode,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_addr_en,
  output logic             ready,
  output logic             overflow
);
  localparam int unsigned ROWS         = 1 << ROW_W;
  localparam int unsigned PWR_CYC      = cdiv(POWERUP_NS, CLK_PERIOD_NS);
  localparam int unsigned PRE_CYC      = cdiv(PRECHARGE_NS, CLK_PERIOD_NS);
  localparam int unsigned CYC_CYC      = cdiv(CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned RAS_CYC      = umax(cdiv(RAS_LOW_NS, CLK_PERIOD_NS),
                                              (CYC_CYC > PRE_CYC + 1) ? CYC_CYC - PRE_CYC - 1 : 1);
  localparam int unsigned INTERVAL_CYC = RETENTION_NS / ROWS / CLK_PERIOD_NS;

  logic tick;
  logic owed;
  logic served;

  rfsh_interval_timer #(
    .PERIOD_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ready),
    .tick (tick)
  );

  rfsh_debt_counter #(
    .MAX_DEBT(MAX_DEBT)
  ) u_debt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .served  (served),
    .owed    (owed),
    .overflow(overflow)
  );

  rfsh_cycle_fsm #(
    .PWR_CYC    (PWR_CYC),
    .RAS_CYC    (RAS_CYC),
    .PRE_CYC    (PRE_CYC),
    .INIT_CYCLES(INIT_CYCLES),
    .ROW_W      (ROW_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .owed         (owed),
    .bus_gnt      (bus_gnt),
    .ras_only_mode(ras_only_mode),
    .bus_req      (bus_req),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .row_addr_en  (row_addr_en),
    .row_addr     (row_addr),
    .ready        (ready),
    .served       (served)
  );

  // Write enable never drops, so a CAS-first cycle is never a test-mode entry.
  assign we_n = 1'b1;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned RAS_CYC = 8,
  parameter int unsigned PRE_CYC = 5,
  parameter int unsigned ROW_W   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             row_addr_en,
  input logic             ready,
  input logic             overflow
);
  localparam int unsigned KW = $clog2(((RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC) + 2);

  logic [KW-1:0] hi_cnt, lo_cnt;
  logic          seen_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      seen_low <= 1'b0;
    end else begin
      if (!ras_n) seen_low <= 1'b1;
      if (ras_n) begin
        lo_cnt <= '0;
        if (hi_cnt != '1) hi_cnt <= hi_cnt + KW'(1);
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != '1) lo_cnt <= lo_cnt + KW'(1);
      end
    end
  end

  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n || row_addr_en) |-> bus_req); // R5
  AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0)); // R6
  AST_CAS_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !row_addr_en); // R6
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && row_addr_en) |-> ($stable(row_addr) && $past(row_addr_en))); // R7
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= KW'(RAS_CYC))); // R8
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && seen_low) |-> (hi_cnt >= KW'(PRE_CYC))); // R8
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .RAS_CYC(RAS_CYC),
  .PRE_CYC(PRE_CYC),
  .ROW_W  (ROW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .row_addr   (row_addr),
  .row_addr_en(row_addr_en),
  .ready      (ready),
  .overflow   (overflow)
);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;
  localparam int CLK_NS    = 8;
  localparam int PWR_NS    = 400;
  localparam int INIT_N    = 8;
  localparam int ROW_W     = 3;
  localparam int ROWS      = 1 << ROW_W;
  localparam int RET_NS    = ROWS * 3200;
  localparam int MAX_DEBT  = 8;
  // Values derived from the requirements
  localparam int PWR_CYC   = (PWR_NS + CLK_NS - 1) / CLK_NS;        // 50
  localparam int PRE_CYC   = (40 + CLK_NS - 1) / CLK_NS;            // 5
  localparam int CYC_CYC   = (110 + CLK_NS - 1) / CLK_NS;           // 14
  localparam int RAS_A     = (60 + CLK_NS - 1) / CLK_NS;            // 8
  localparam int RAS_CYC   = (RAS_A > CYC_CYC - PRE_CYC - 1) ? RAS_A : CYC_CYC - PRE_CYC - 1;
  localparam int INTERVAL  = RET_NS / ROWS / CLK_NS;                // 400

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b1;
  logic gnt_en = 1'b1;
  logic bus_req, bus_gnt, ras_n, cas_n, we_n, row_addr_en, ready, overflow;
  logic [ROW_W-1:0] row_addr;

  int checks = 0;
  int errors = 0;
  int falls = 0;
  int init_falls = 0;
  bit exp_mode = 1'b1;

  always #4 clk = ~clk;
  assign bus_gnt = gnt_en & bus_req;

  dram_refresh_seq #(
    .CLK_PERIOD_NS(CLK_NS), .POWERUP_NS(PWR_NS), .INIT_CYCLES(INIT_N),
    .ROW_W(ROW_W), .RETENTION_NS(RET_NS), .RAS_LOW_NS(60),
    .PRECHARGE_NS(40), .CYCLE_NS(110), .MAX_DEBT(MAX_DEBT)
  ) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ras_only_mode(mode), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .row_addr(row_addr), .row_addr_en(row_addr_en), .ready(ready),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Strobe monitor, sampled on the falling clock edge
  bit prev_ras = 1, prev_cas = 1, prev_en = 0, prev_rdy = 0, seen_fall = 0;
  int ras_lo = 0, ras_hi = 0, gap = 0, exp_row = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1; prev_cas = 1; prev_en = 0; prev_rdy = 0;
      seen_fall = 0; ras_lo = 0; ras_hi = 0; gap = 0; exp_row = 0; init_falls = 0;
    end else begin
      gap++;
      if (prev_ras && !ras_n) begin
        falls++;
        if (!ready) init_falls++;
        chk(bus_req, "R5 strobe without bus ownership", bus_req, 1);
        if (seen_fall) begin
          chk(ras_hi >= PRE_CYC, "R8 precharge width", ras_hi, PRE_CYC);
          chk(gap >= CYC_CYC, "R8 fall-to-fall spacing", gap, CYC_CYC);
        end
        seen_fall = 1; gap = 0;
        if (!cas_n) begin
          chk(!prev_cas, "R6 cas before ras", prev_cas, 0);
          chk(we_n, "R6 we_n high", we_n, 1);
          chk(!row_addr_en, "R6 no address in cas-first cycle", row_addr_en, 0);
          chk(exp_mode == 1'b0, "R10 cycle form", 0, exp_mode);
        end else begin
          chk(row_addr_en && prev_en, "R7 address enabled before ras", {prev_en, row_addr_en}, 3);
          chk(int'(row_addr) == exp_row, "R7 row sequence", int'(row_addr), exp_row);
          exp_row = (exp_row + 1) % ROWS;
          chk(exp_mode == 1'b1, "R10 cycle form", 1, exp_mode);
        end
      end
      if (ras_n) begin
        if (!prev_ras) chk(ras_lo >= RAS_CYC, "R8 ras low width", ras_lo, RAS_CYC);
        ras_lo = 0; ras_hi++;
      end else begin
        ras_hi = 0; ras_lo++;
        if (!cas_n) chk(!row_addr_en, "R7 cas high in ras-only", cas_n, 1);
      end
      if (ready && !prev_rdy) begin
        chk(init_falls == INIT_N, "R3 init cycle count", init_falls, INIT_N);
        chk(ras_n && cas_n, "R3 ready after cycle ends", {ras_n, cas_n}, 3);
      end
      if (prev_rdy) chk(ready, "R3 ready holds", ready, 1);
      prev_ras = ras_n; prev_cas = cas_n; prev_en = row_addr_en; prev_rdy = ready;
    end
  end

  task automatic check_reset_state();
    chk(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
    chk(!bus_req && !row_addr_en, "R1 no request", {bus_req, row_addr_en}, 0);
    chk(!ready && !overflow, "R1 status clear", {ready, overflow}, 0);
  endtask

  task automatic wait_idle();
    while (bus_req) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int f0;
    repeat (5) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    // R2: count clocks until the first bus request
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!bus_req) chk(ras_n && cas_n && !row_addr_en, "R2 quiet during hold", 0, 0);
    end while (!bus_req && n < 10 * PWR_CYC);
    chk(n >= PWR_CYC && n <= PWR_CYC + 1, "R2 power-up hold", n, PWR_CYC);

    // R3 and R7: initialisation in RAS-only form covers all rows
    while (!ready) @(negedge clk);

    // R4 and R6: ten slots of CAS-before-RAS refresh
    mode = 1'b0; exp_mode = 1'b0;
    f0 = falls;
    repeat (10 * INTERVAL + INTERVAL / 2) @(negedge clk);
    chk(falls - f0 == 10, "R4 cadence cas-first", falls - f0, 10);

    // R4, R7 and R10: ten slots of RAS-only refresh, passing the row wrap
    wait_idle();
    mode = 1'b1; exp_mode = 1'b1;
    f0 = falls;
    repeat (10 * INTERVAL) @(negedge clk);
    chk(falls - f0 == 10, "R4 cadence ras-only", falls - f0, 10);

    // R5 and R9: withhold the grant
    wait_idle();
    mode = 1'b0; exp_mode = 1'b0;
    while (!bus_req) @(negedge clk);
    wait_idle();
    gnt_en = 1'b0;
    f0 = falls;
    repeat (8 * INTERVAL + 3 * INTERVAL / 10) @(negedge clk);
    chk(!overflow, "R9 no overflow at full debt", overflow, 0);
    chk(bus_req, "R5 request held while waiting", bus_req, 1);
    repeat (INTERVAL) @(negedge clk);
    chk(overflow, "R9 overflow on extra tick", overflow, 1);
    chk(falls == f0, "R5 no cycle without grant", falls - f0, 0);
    gnt_en = 1'b1;
    f0 = falls;
    repeat (200) @(negedge clk);
    chk(falls - f0 == MAX_DEBT, "R9 owed refreshes served", falls - f0, MAX_DEBT);
    chk(overflow, "R9 overflow sticky", overflow, 1);

    // R1: reset again clears everything
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule